// File: doc/BRIEF.md
# Cascaded Two-Stage Signed Multiplier

This block produces the exact 62-bit two's-complement product of a 27-bit signed operand and a 35-bit signed operand. The product is built from two multiply-add stages, and neither stage multiplies anything wider than 27 by 18 signed bits. The 35-bit operand is cut into a 17-bit low slice and an 18-bit high slice. The first stage multiplies the 27-bit operand by the low slice. Its 48-bit result travels to the second stage on a partial-sum path. There it is shifted right arithmetically by 17 places and added to the product of the 27-bit operand and the high slice.

The bottom 17 bits of the final product are complete one cycle before the upper bits. A single register holds them back so that the two parts line up. The final product is the second stage's upper 45 bits placed above those delayed 17 bits.

A valid flag travels alongside the data. A new operand pair can be accepted on every clock. Each result appears exactly four cycles after its pair is presented, and out_valid is high in that cycle. The design has no state machine. Its only control is the valid shift register, and its only state besides that is the data pipeline, whose four register levels run in a fixed order: operand capture, low partial product, cascade sum, output.

Top module: `cascade_mult`

## Requirements
- R1: When out_valid is high, `product` equals the full signed product `a_in * b_in` of the pair that was presented with in_valid four cycles earlier. No bits are truncated, rounded or saturated.
- R2: out_valid goes high exactly 4 clock cycles after a cycle in which in_valid was sampled high with rst low. The matching product is on `product` in that same cycle.
- R3: A new pair is accepted on every cycle that in_valid is high, including consecutive cycles. A cycle in which in_valid is low gives out_valid low four cycles later.
- R4: Synchronous reset clears every pipeline register. While rst is sampled high, out_valid is 0 and `product` is 0 in the following cycle. Pairs that were in flight when reset arrived never produce out_valid, and in_valid is ignored while rst is high.
- R5: The extreme operands give exact results. These are a_in = -2^26 or 2^26-1 combined with b_in = -2^34 or 2^34-1. For example, (-2^26)*(-2^34) = +2^60.
- R6: If either operand is zero, the product is zero.
- R7: The low slice, `b_in[16:0]`, is an unsigned quantity. A pair whose bit 16 of b_in is set still gives the exact product, for example b_in = 0x1FFFF or b_in = -1.
- R8: The partial sum is shifted right arithmetically by 17 bits. A negative a_in with a nonzero low slice still gives the exact negative product, including when the high slice `b_in[34:17]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The pair on a_in/b_in is to be multiplied |
| a_in | input | 27 | Signed multiplicand |
| b_in | input | 35 | Signed multiplier; bits 16:0 form the low slice and bits 34:17 the high slice |
| out_valid | output | 1 | product holds a result this cycle |
| product | output | 62 | Signed product |

## Verification
A wrong sign or a missing sign extension anywhere on the cascade path corrupts the upper 45 product bits. This shows up four cycles after the offending pair, and most clearly for negative multiplicands and low slices with bit 16 set. A misaligned delay register on the low 17 bits shows the neighbouring pair's low bits in the product at once, provided the stream runs back to back. That is why random pairs are applied on consecutive cycles. A broken valid pipe or reset path shows as out_valid one cycle early or late, or as a stale pulse after a mid-stream reset.

// File: rtl/cascade_mult_pkg.sv
package cascade_mult_pkg;
    // Default geometry of the split multiplier
    localparam int unsigned MUL_A_W   = 27;  // narrow signed operand
    localparam int unsigned MUL_B_W   = 35;  // wide signed operand
    localparam int unsigned MUL_LO_W  = 17;  // unsigned low slice / cascade shift
    localparam int unsigned MUL_CAS_W = 48;  // partial-sum path width
    localparam int unsigned MUL_LAT   = 4;   // register levels, input to output

    function automatic int unsigned max_u(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction
endpackage

// File: rtl/cascade_mult_stage.sv
// One multiply-add stage: p_q <= a * b + (casc_in >>> SHIFT)
module cascade_mult_stage #(
    parameter int unsigned A_W   = 27,
    parameter int unsigned B_W   = 18,
    parameter int unsigned CW    = 48,
    parameter int unsigned SHIFT = 17
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [A_W-1:0] a_in,
    input  logic signed [B_W-1:0] b_in,
    input  logic signed [CW-1:0]  casc_in,
    output logic signed [CW-1:0]  p_out
);
    logic signed [CW-1:0] a_ext;
    logic signed [CW-1:0] b_ext;
    logic signed [CW-1:0] addend;
    logic signed [CW-1:0] p_next;
    logic signed [CW-1:0] p_q;

    always_comb begin
        a_ext  = CW'(a_in);
        b_ext  = CW'(b_in);
        addend = casc_in >>> SHIFT;
        p_next = (a_ext * b_ext) + addend;
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_next;
    end

    assign p_out = p_q;

    // R6
    zero_pp_chk: assert property (@(posedge clk) disable iff (rst)
        (a_in == '0 || b_in == '0) |=> (p_out == ($signed($past(casc_in)) >>> SHIFT)));
endmodule

// File: rtl/cascade_mult_vpipe.sv
// Valid flag delay line matching the data path depth
module cascade_mult_vpipe #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic v_in,
    output logic v_out
);
    generate
        if (DEPTH == 1) begin : g_single
            logic v_q;
            always_ff @(posedge clk) begin
                if (rst) v_q <= 1'b0;
                else     v_q <= v_in;
            end
            assign v_out = v_q;
        end else begin : g_chain
            logic [DEPTH-1:0] v_q;
            always_ff @(posedge clk) begin
                if (rst) v_q <= '0;
                else     v_q <= {v_q[DEPTH-2:0], v_in};
            end
            assign v_out = v_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/cascade_mult.sv
module cascade_mult
    import cascade_mult_pkg::*;
#(
    parameter int unsigned A_W   = MUL_A_W,
    parameter int unsigned B_W   = MUL_B_W,
    parameter int unsigned LO_W  = MUL_LO_W,
    parameter int unsigned CAS_W = MUL_CAS_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [A_W-1:0]      a_in,
    input  logic signed [B_W-1:0]      b_in,
    output logic                       out_valid,
    output logic signed [A_W+B_W-1:0]  product
);
    localparam int unsigned PROD_W = A_W + B_W;
    localparam int unsigned HI_W   = B_W - LO_W;
    localparam int unsigned UP_W   = PROD_W - LO_W;
    localparam int unsigned STG_BW = max_u(LO_W + 1, HI_W);
    localparam int unsigned LAT    = MUL_LAT;

    // Level 0: operand capture
    logic signed [A_W-1:0]    a_r;
    logic signed [B_W-1:0]    b_r;
    // Level 1: forwarded operands for the second stage
    logic signed [A_W-1:0]    a_d;
    logic signed [STG_BW-1:0] hi_d;
    // Slice operands
    logic signed [STG_BW-1:0] lo_op;
    logic signed [STG_BW-1:0] hi_op;
    // Stage results
    logic signed [CAS_W-1:0]  p1;
    logic signed [CAS_W-1:0]  p2;
    // Level 2: delay-matched low result bits
    logic [LO_W-1:0]          lo_d;
    // Level 3: output register
    logic signed [PROD_W-1:0] prod_q;

    always_comb begin
        lo_op = STG_BW'({1'b0, b_r[LO_W-1:0]});
        hi_op = STG_BW'($signed(b_r[B_W-1:LO_W]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_r    <= '0;
            b_r    <= '0;
            a_d    <= '0;
            hi_d   <= '0;
            lo_d   <= '0;
            prod_q <= '0;
        end else begin
            a_r    <= a_in;
            b_r    <= b_in;
            a_d    <= a_r;
            hi_d   <= hi_op;
            lo_d   <= p1[LO_W-1:0];
            prod_q <= {p2[UP_W-1:0], lo_d};
        end
    end

    cascade_mult_stage #(
        .A_W(A_W), .B_W(STG_BW), .CW(CAS_W), .SHIFT(LO_W)
    ) u_stage_lo (
        .clk(clk), .rst(rst), .a_in(a_r), .b_in(lo_op),
        .casc_in('0), .p_out(p1)
    );

    cascade_mult_stage #(
        .A_W(A_W), .B_W(STG_BW), .CW(CAS_W), .SHIFT(LO_W)
    ) u_stage_hi (
        .clk(clk), .rst(rst), .a_in(a_d), .b_in(hi_d),
        .casc_in(p1), .p_out(p2)
    );

    cascade_mult_vpipe #(.DEPTH(LAT)) u_vpipe (
        .clk(clk), .rst(rst), .v_in(in_valid), .v_out(out_valid)
    );

    assign product = prod_q;

    // Cycles since reset, saturating, so that $past never reaches before reset
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R2
    lat_vld_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'(LAT)) |-> (out_valid == $past(in_valid, 4)));

    // R4
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0));

    // R6
    zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'(LAT) && out_valid &&
         ($past(a_in, 4) == '0 || $past(b_in, 4) == '0)) |-> (product == '0));

    // R1
    sign_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'(LAT) && out_valid &&
         $past(a_in, 4) != '0 && $past(b_in, 4) != '0)
        |-> (product[PROD_W-1] == ($past(a_in[A_W-1], 4) ^ $past(b_in[B_W-1], 4))));

    // R8
    casc_fit_chk: assert property (@(posedge clk) disable iff (rst)
        (&p2[CAS_W-1:UP_W-1]) || !(|p2[CAS_W-1:UP_W-1]));
endmodule

// File: tb/cascade_mult_bench.sv
`timescale 1ns/1ps
module cascade_mult_bench;
    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic signed [26:0] a_in;
    logic signed [34:0] b_in;
    logic               out_valid;
    logic signed [61:0] product;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit prev_r = 1'b1;

    bit                 ring_v [8];
    logic signed [61:0] ring_p [8];
    string              ring_t [8];

    localparam logic signed [26:0] A_MIN = 27'sh4000000;
    localparam logic signed [26:0] A_MAX = 27'sh3FFFFFF;
    localparam logic signed [34:0] B_MIN = 35'sh400000000;
    localparam logic signed [34:0] B_MAX = 35'sh3FFFFFFFF;

    always #2 clk = ~clk;

    cascade_mult u_cascade_mult (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid), .product(product)
    );

    function automatic logic signed [61:0] ref_mul(input logic signed [26:0] x,
                                                   input logic signed [34:0] y);
        logic signed [61:0] xx;
        logic signed [61:0] yy;
        xx = x;
        yy = y;
        return xx * yy;
    endfunction

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One clock: check the output due now, then drive the next inputs
    task automatic step(input bit r, input bit v, input logic signed [26:0] av,
                        input logic signed [34:0] bv, input string tag);
        int ci;
        @(negedge clk);
        ci = (cyc + 4) % 8;
        checks++;
        if (prev_r) begin
            if (out_valid !== 1'b0 || product !== 62'sd0) begin
                fails++;
                $display("FAIL R4: out_valid=%0b product=%0d expected out_valid=0 product=0",
                         out_valid, product);
            end
        end else if (ring_v[ci]) begin
            if (out_valid !== 1'b1 || product !== ring_p[ci]) begin
                fails++;
                $display("FAIL %s: out_valid=%0b product=%0d expected out_valid=1 product=%0d",
                         ring_t[ci], out_valid, product, ring_p[ci]);
            end
        end else begin
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL %s: out_valid=%0b expected out_valid=0", ring_t[ci], out_valid);
            end
        end
        if (r) begin
            for (int k = 0; k < 8; k++) ring_v[k] = 1'b0;
        end
        ring_v[cyc % 8] = v && !r;
        ring_p[cyc % 8] = ref_mul(av, bv);
        ring_t[cyc % 8] = tag;
        rst      = r;
        in_valid = v;
        a_in     = av;
        b_in     = bv;
        prev_r   = r;
        cyc++;
    endtask

    task automatic rand_pair(output logic signed [26:0] av, output logic signed [34:0] bv);
        logic [31:0] r32;
        logic [63:0] r64;
        r32 = $urandom();
        r64 = {$urandom(), $urandom()};
        av  = r32[26:0];
        bv  = r64[34:0];
    endtask

    initial begin
        logic signed [26:0] ra;
        logic signed [34:0] rb;
        logic [31:0]        rv;
        rst = 1'b1; in_valid = 1'b0; a_in = '0; b_in = '0;
        void'($urandom(32'd777));
        for (int k = 0; k < 8; k++) begin ring_v[k] = 1'b0; ring_p[k] = '0; ring_t[k] = "R2"; end

        // R4: reset held with in_valid high must produce nothing
        repeat (3) step(1'b1, 1'b1, A_MAX, B_MAX, "R4");
        repeat (4) step(1'b0, 1'b0, '0, '0, "R4");

        // R5: extremes, back to back
        step(1'b0, 1'b1, A_MIN, B_MIN, "R5");
        step(1'b0, 1'b1, A_MAX, B_MAX, "R5");
        step(1'b0, 1'b1, A_MIN, B_MAX, "R5");
        step(1'b0, 1'b1, A_MAX, B_MIN, "R5");
        // R6: zero operands
        step(1'b0, 1'b1, '0, B_MIN, "R6");
        step(1'b0, 1'b1, A_MIN, '0, "R6");
        step(1'b0, 1'b1, '0, '0, "R6");
        // R7: low slice with bit 16 set is unsigned
        step(1'b0, 1'b1, A_MAX, 35'sh00001FFFF, "R7");
        step(1'b0, 1'b1, A_MIN, 35'sh000010000, "R7");
        step(1'b0, 1'b1, 27'sd12345, -35'sd1, "R7");
        // R8: negative first partial, arithmetic shift
        step(1'b0, 1'b1, -27'sd5, 35'sh00001FFFF, "R8");
        step(1'b0, 1'b1, A_MIN, 35'sd3, "R8");
        step(1'b0, 1'b1, -27'sd1, 35'sd1, "R8");
        step(1'b0, 1'b1, -27'sd77, 35'sh7FFFE0001, "R8");
        // R2: single isolated pair, then idle
        step(1'b0, 1'b0, '0, '0, "R2");
        step(1'b0, 1'b1, 27'sd3, -35'sd7, "R2");
        repeat (5) step(1'b0, 1'b0, '0, '0, "R2");

        // R1 / R3: random pairs every cycle
        for (int n = 0; n < 3000; n++) begin
            rand_pair(ra, rb);
            step(1'b0, 1'b1, ra, rb, "R1");
        end
        // R3: random gaps in the stream
        for (int n = 0; n < 1000; n++) begin
            rand_pair(ra, rb);
            rv = $urandom();
            step(1'b0, rv[0], ra, rb, "R3");
        end

        // R4: reset in mid stream discards pairs in flight
        for (int n = 0; n < 3; n++) begin
            rand_pair(ra, rb);
            step(1'b0, 1'b1, ra, rb, "R4");
        end
        step(1'b1, 1'b1, A_MIN, B_MIN, "R4");
        repeat (6) step(1'b0, 1'b0, '0, '0, "R4");
        rand_pair(ra, rb);
        step(1'b0, 1'b1, ra, rb, "R1");
        repeat (6) step(1'b0, 1'b0, '0, '0, "R2");

        report();
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL R2: watchdog expired at cycle %0d expected completion", cyc);
        report();
        $finish;
    end
endmodule